// File: doc/BRIEF.md
# Descriptor-Driven Stream Prefetch Engine

This block walks a single memory stream described by software and turns it into a series of cache-line prefetch requests. Software, or code a compiler emits, provides a base address, a byte length, a byte stride and a one-bit locality hint, then pulses a start input. The engine forms the addresses `base + k*stride` for every k with `k*stride < length`. It converts each address to a line number (line size `LINE_BYTES`, 64 by default) and hands the line numbers one at a time to the cache. Each request carries the hint.

A request is launched only in a cycle when the core's memory port is free of genuine loads and stores. Once launched, a request stays on the output, unchanged, until the cache accepts it through a valid/ready handshake. When the stride is shorter than a line, consecutive addresses that land in the line just requested are skipped, at one candidate per cycle. A start pulse at any time discards the stream in progress and loads the new descriptor.

The controller has four states:
- `ST_IDLE`: after reset, nothing to do.
- `ST_SCAN`: evaluates the current candidate address.
- `ST_HOLD`: a launched request is waiting for acceptance.
- `ST_DONE`: the stream is finished.

Its transitions are:
- start to `ST_SCAN`, or to `ST_DONE` for a zero length.
- `ST_SCAN` stays in `ST_SCAN` on a skip, a busy port or an accepted request.
- `ST_SCAN` goes to `ST_HOLD` when a launched request is not accepted.
- `ST_SCAN` goes to `ST_DONE` when the offset reaches the length, or on acceptance with a zero stride.
- `ST_HOLD` goes to `ST_SCAN` (or `ST_DONE` for a zero stride) on acceptance.
- Any state goes back to `ST_SCAN` or `ST_DONE` on start.

`STRIDE_W` must not exceed `LEN_W`.

Top module: `spf_engine`

## Requirements
- R1: After reset `eng_busy`, `eng_done` and `pf_valid` are all 0.
- R2: A start with nonzero length clears `eng_done` and sets `eng_busy` on the next cycle. The accepted line numbers (`pf_line` = address bits [ADDR_W-1:6] of `(base + k*stride) mod 2^ADDR_W`) appear in increasing k, with one request per k when the stride is at least a line.
- R3: A request that is not carried over from an unaccepted one is presented (`pf_valid` = 1) only in a cycle where `mem_port_busy` is 0.
- R4: While `pf_valid` is 1 and `pf_ready` is 0 (and no start), the next cycle still has `pf_valid` = 1 with the same `pf_line` and `pf_temporal`.
- R5: Every accepted request carries `pf_temporal` equal to the hint given with the start pulse.
- R6: With a stride below the line size, an address whose line equals the most recently requested line is not requested again. The accepted list is the k-ordered line list with consecutive duplicates removed.
- R7: After the last acceptance, the engine reaches `eng_done` = 1 with `eng_busy` = 0 and `pf_valid` = 0. It stays there until the next start.
- R8: A start with length 0 issues no request, and `eng_done` is 1 on the cycle after the start.
- R9: A start while busy abandons the old stream, and the next accepted line is the new stream's first line. A handshake completing in the start cycle itself belongs to the old stream.
- R10: A stride of 0 with nonzero length issues exactly one request (the base line), then completes.
- R11: The descriptor inputs are sampled only in the start cycle; changing them later has no effect on the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-cycle pulse loading a descriptor |
| cfg_base | input | ADDR_W | Stream base byte address |
| cfg_len | input | LEN_W | Stream length in bytes |
| cfg_stride | input | STRIDE_W | Byte distance between stream elements |
| cfg_temporal | input | 1 | Locality hint: 1 keep long, 0 short-lived |
| mem_port_busy | input | 1 | Memory port carries a real load or store this cycle |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Cache accepts the request |
| pf_line | output | ADDR_W-log2(LINE_BYTES) | Line number to prefetch |
| pf_temporal | output | 1 | Hint travelling with the request |
| eng_busy | output | 1 | A stream is being walked |
| eng_done | output | 1 | The last stream has completed |

## Verification
Two events can meet in one cycle: the cache accepting a held request, and a new start pulse that aborts the stream. The bench parks a request by holding `pf_ready` low with the port idle. It then raises `pf_ready` in the same cycle as a start with a different descriptor. The accepted line must be the old stream's line with the old hint, and the lines that follow must be exactly the new stream's arithmetic list. A second case starts over a held request that is never accepted, and the new stream's first line must then come first.

// File: rtl/spf_pkg.sv
package spf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2,
        ST_DONE = 2'd3
    } spf_state_e;

endpackage

// File: rtl/spf_desc_latch.sv
module spf_desc_latch #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int STRIDE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic                temporal_i,
    output logic [ADDR_W-1:0]   base_o,
    output logic [LEN_W-1:0]    len_o,
    output logic [STRIDE_W-1:0] stride_o,
    output logic                temporal_o,
    output logic                stride_zero_o
);

    // Descriptor fields only change on a start pulse (R11).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_o     <= '0;
            len_o      <= '0;
            stride_o   <= '0;
            temporal_o <= 1'b0;
        end else if (load_i) begin
            base_o     <= base_i;
            len_o      <= len_i;
            stride_o   <= stride_i;
            temporal_o <= temporal_i;
        end
    end

    assign stride_zero_o = (stride_o == '0);

    // R11: without a load the stored descriptor does not move
    a_r11_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(base_o) && $stable(len_o) && $stable(stride_o) && $stable(temporal_o));

endmodule

// File: rtl/spf_walker.sv
module spf_walker #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int STRIDE_W   = 12,
    parameter int LINE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart_i,
    input  logic                    advance_i,
    input  logic                    mark_i,
    input  logic [ADDR_W-1:0]       base_i,
    input  logic [LEN_W-1:0]        len_i,
    input  logic [STRIDE_W-1:0]     stride_i,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] cand_line_o,
    output logic                    at_end_o,
    output logic                    same_line_o
);

    localparam int LB    = $clog2(LINE_BYTES);
    localparam int LA_W  = ADDR_W - LB;
    localparam int OFF_W = LEN_W + 1;

    logic [OFF_W-1:0]  offset_q;
    logic [LA_W-1:0]   last_q;
    logic              have_q;
    logic [ADDR_W-1:0] cand_addr;
    logic              unused_low;

    // Candidate byte address wraps modulo the address width.
    assign cand_addr   = base_i + ADDR_W'(offset_q);
    assign cand_line_o = cand_addr[ADDR_W-1:LB];
    assign unused_low  = ^cand_addr[LB-1:0];

    assign at_end_o    = (offset_q >= {1'b0, len_i});
    assign same_line_o = have_q && (cand_line_o == last_q);

    // Offset: one stride per advance, extra bit keeps the sum exact.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (restart_i) begin
            offset_q <= '0;
        end else if (advance_i) begin
            offset_q <= offset_q + OFF_W'(stride_i);
        end
    end

    // Line most recently handed to the cache, for the skip test.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            have_q <= 1'b0;
        end else if (restart_i) begin
            have_q <= 1'b0;
        end else if (mark_i) begin
            last_q <= cand_line_o;
            have_q <= 1'b1;
        end
    end

    // R6: a line just requested is never requested again back to back
    a_r6_no_repeat_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_i && !restart_i && have_q) |-> (cand_line_o != last_q));

    // R7: the walker never moves past the end of the stream
    a_r7_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !restart_i) |-> !at_end_o);

endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl
    import spf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic start_len_zero_i,
    input  logic mem_busy_i,
    input  logic pf_ready_i,
    input  logic at_end_i,
    input  logic same_line_i,
    input  logic stride_zero_i,
    output logic advance_o,
    output logic mark_o,
    output logic pf_valid_o,
    output logic busy_o,
    output logic done_o
);

    spf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        advance_o  = 1'b0;
        mark_o     = 1'b0;
        pf_valid_o = 1'b0;
        busy_o     = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SCAN: begin
                busy_o = 1'b1;
                if (at_end_i) begin
                    state_d = ST_DONE;
                end else if (same_line_i) begin
                    advance_o = 1'b1;
                end else if (!mem_busy_i) begin
                    pf_valid_o = 1'b1;
                    if (pf_ready_i) begin
                        advance_o = 1'b1;
                        mark_o    = 1'b1;
                        if (stride_zero_i) begin
                            state_d = ST_DONE;
                        end
                    end else begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                busy_o     = 1'b1;
                pf_valid_o = 1'b1;
                if (pf_ready_i) begin
                    advance_o = 1'b1;
                    mark_o    = 1'b1;
                    state_d   = stride_zero_i ? ST_DONE : ST_SCAN;
                end
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        // A start pulse overrides everything else in the cycle.
        if (start_i) begin
            state_d   = start_len_zero_i ? ST_DONE : ST_SCAN;
            advance_o = 1'b0;
            mark_o    = 1'b0;
        end
    end

    // R10: an accepted request with zero stride ends the stream
    a_r10_zero_stride_single: assert property (@(posedge clk) disable iff (!rst_n)
        (stride_zero_i && pf_valid_o && pf_ready_i && !start_i) |=> done_o);

    // R7: done and busy are exclusive
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

endmodule

// File: rtl/spf_engine.sv
module spf_engine #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int STRIDE_W   = 12,
    parameter int LINE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_start,
    input  logic [ADDR_W-1:0]       cfg_base,
    input  logic [LEN_W-1:0]        cfg_len,
    input  logic [STRIDE_W-1:0]     cfg_stride,
    input  logic                    cfg_temporal,
    input  logic                    mem_port_busy,
    output logic                    pf_valid,
    input  logic                    pf_ready,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] pf_line,
    output logic                    pf_temporal,
    output logic                    eng_busy,
    output logic                    eng_done
);

    localparam int LA_W = ADDR_W - $clog2(LINE_BYTES);

    logic [ADDR_W-1:0]   d_base;
    logic [LEN_W-1:0]    d_len;
    logic [STRIDE_W-1:0] d_stride;
    logic                d_temporal;
    logic                d_stride_zero;
    logic                w_at_end;
    logic                w_same_line;
    logic [LA_W-1:0]     w_line;
    logic                c_advance;
    logic                c_mark;
    logic                start_len_zero;

    assign start_len_zero = (cfg_len == '0);

    spf_desc_latch #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .STRIDE_W (STRIDE_W)
    ) u_desc (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (cfg_start),
        .base_i        (cfg_base),
        .len_i         (cfg_len),
        .stride_i      (cfg_stride),
        .temporal_i    (cfg_temporal),
        .base_o        (d_base),
        .len_o         (d_len),
        .stride_o      (d_stride),
        .temporal_o    (d_temporal),
        .stride_zero_o (d_stride_zero)
    );

    spf_walker #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .STRIDE_W   (STRIDE_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (cfg_start),
        .advance_i   (c_advance),
        .mark_i      (c_mark),
        .base_i      (d_base),
        .len_i       (d_len),
        .stride_i    (d_stride),
        .cand_line_o (w_line),
        .at_end_o    (w_at_end),
        .same_line_o (w_same_line)
    );

    spf_ctrl u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (cfg_start),
        .start_len_zero_i (start_len_zero),
        .mem_busy_i       (mem_port_busy),
        .pf_ready_i       (pf_ready),
        .at_end_i         (w_at_end),
        .same_line_i      (w_same_line),
        .stride_zero_i    (d_stride_zero),
        .advance_o        (c_advance),
        .mark_o           (c_mark),
        .pf_valid_o       (pf_valid),
        .busy_o           (eng_busy),
        .done_o           (eng_done)
    );

    assign pf_line     = w_line;
    assign pf_temporal = d_temporal;

    // R3: a freshly presented request only appears on an idle port cycle
    a_r3_launch_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !$past(pf_valid && !pf_ready)) |-> !mem_port_busy);

    // R4: an unaccepted request is held unchanged
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !cfg_start) |=> pf_valid && $stable(pf_line) && $stable(pf_temporal));

    // R7: a finished engine is quiet
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> (!eng_busy && !pf_valid));

    // R8: an empty stream completes on the next cycle
    a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_start && cfg_len == '0) |=> eng_done);

    // R2: a nonempty start makes the engine busy next cycle
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_start && cfg_len != '0) |=> (eng_busy && !eng_done));

endmodule

// File: tb/sim_spf_engine.sv
`timescale 1ns/1ps
module sim_spf_engine;

    localparam int AW = 16;
    localparam int LW = 10;
    localparam int SW = 8;
    localparam int LBYTES = 64;
    localparam int LA = AW - 6;
    localparam int WATCHDOG = 150000;

    logic          clk;
    logic          rst_n;
    logic          cfg_start;
    logic [AW-1:0] cfg_base;
    logic [LW-1:0] cfg_len;
    logic [SW-1:0] cfg_stride;
    logic          cfg_temporal;
    logic          mem_port_busy;
    logic          pf_valid;
    logic          pf_ready;
    logic [LA-1:0] pf_line;
    logic          pf_temporal;
    logic          eng_busy;
    logic          eng_done;

    spf_engine #(.ADDR_W(AW), .LEN_W(LW), .STRIDE_W(SW), .LINE_BYTES(LBYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_stride(cfg_stride), .cfg_temporal(cfg_temporal),
        .mem_port_busy(mem_port_busy), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_line(pf_line), .pf_temporal(pf_temporal), .eng_busy(eng_busy),
        .eng_done(eng_done)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    int exp_lines [0:511];
    int exp_n;
    int exp_hint;
    int steps_taken;

    logic          d_start = 0;
    logic [AW-1:0] d_base = 0;
    logic [LW-1:0] d_len = 0;
    logic [SW-1:0] d_stride = 0;
    logic          d_temp = 0;
    int force_busy = 0;
    int force_ready = 0;

    logic prev_valid = 0, prev_ready = 0, prev_start = 0, prev_hint = 0;
    int   prev_line = 0;
    logic hs = 0;
    int   hs_line = 0;
    logic hs_hint = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, WATCHDOG);
            finish_run();
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cfg_start     = d_start;
        cfg_base      = d_base;
        cfg_len       = d_len;
        cfg_stride    = d_stride;
        cfg_temporal  = d_temp;
        mem_port_busy = (force_busy < 0) ? (lfsr[0] & lfsr[3]) : force_busy[0];
        pf_ready      = (force_ready < 0) ? !(lfsr[5] & lfsr[8]) : force_ready[0];
        #1;
        if (pf_valid && !(prev_valid && !prev_ready))
            chk(!mem_port_busy, "R3", "new request on busy port", int'(mem_port_busy), 0);
        if (prev_valid && !prev_ready && !prev_start) begin
            chk(pf_valid, "R4", "held valid", int'(pf_valid), 1);
            chk(int'(pf_line) == prev_line, "R4", "held line", int'(pf_line), prev_line);
            chk(pf_temporal == prev_hint, "R4", "held hint", int'(pf_temporal), int'(prev_hint));
        end
        hs      = pf_valid && pf_ready;
        hs_line = int'(pf_line);
        hs_hint = pf_temporal;
        prev_valid = pf_valid;
        prev_ready = pf_ready;
        prev_start = cfg_start;
        prev_line  = int'(pf_line);
        prev_hint  = pf_temporal;
    endtask

    // Arithmetic model: line of each k*stride < len, consecutive repeats dropped.
    task automatic compute_exp(input int base, input int len, input int stride, input int hint);
        exp_n = 0;
        exp_hint = hint;
        for (int k = 0; k * stride < len; k++) begin
            int line;
            line = ((base + k * stride) & 16'hFFFF) >> 6;
            if (exp_n == 0 || line != exp_lines[exp_n - 1]) begin
                exp_lines[exp_n] = line;
                exp_n++;
            end
            if (stride == 0) break;
        end
    endtask

    task automatic follow(input string tag);
        int idx = 0;
        steps_taken = 0;
        for (int n = 0; n < 4000; n++) begin
            step();
            steps_taken++;
            if (hs) begin
                if (idx < exp_n)
                    chk(hs_line == exp_lines[idx], tag, "line", hs_line, exp_lines[idx]);
                else
                    chk(0, tag, "extra request", idx, exp_n);
                chk(int'(hs_hint) == exp_hint, "R5", "hint", int'(hs_hint), exp_hint);
                idx++;
            end
            if (eng_done) break;
        end
        chk(idx == exp_n, tag, "request count", idx, exp_n);
        chk(eng_done && !eng_busy, "R7", "done after stream", int'(eng_done), 1);
    endtask

    task automatic start_desc(input int base, input int len, input int stride, input int hint);
        d_start  = 1;
        d_base   = AW'(base);
        d_len    = LW'(len);
        d_stride = SW'(stride);
        d_temp   = hint[0];
    endtask

    task automatic scramble();
        // R11: descriptor inputs move after the start pulse
        d_start  = 0;
        d_base   = ~d_base;
        d_len    = ~d_len;
        d_stride = d_stride + 8'd7;
        d_temp   = ~d_temp;
    endtask

    task automatic run_stream(input int base, input int len, input int stride, input int hint);
        string tag;
        compute_exp(base, len, stride, hint);
        tag = (stride == 0) ? "R10" : (stride < LBYTES) ? "R6" : "R2";
        force_busy = -1;
        force_ready = -1;
        start_desc(base, len, stride, hint);
        step();
        scramble();
        if (len == 0) begin
            follow("R8");
            chk(steps_taken == 1, "R8", "done latency", steps_taken, 1);
        end else begin
            follow(tag);
        end
    endtask

    initial begin
        int strides [9] = '{0, 1, 3, 16, 63, 64, 65, 100, 200};
        int lens [4]    = '{0, 1, 130, 300};
        int bases [3]   = '{0, 37, 16'hFFE5};
        int hint = 0;

        rst_n = 0;
        cfg_start = 0; cfg_base = 0; cfg_len = 0; cfg_stride = 0;
        cfg_temporal = 0; mem_port_busy = 0; pf_ready = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk(!eng_busy, "R1", "busy after reset", int'(eng_busy), 0);
        chk(!eng_done, "R1", "done after reset", int'(eng_done), 0);
        chk(!pf_valid, "R1", "valid after reset", int'(pf_valid), 0);

        // Sweep over base, length and stride (R2 R6 R8 R10 R11)
        foreach (bases[b]) foreach (lens[l]) foreach (strides[s]) begin
            run_stream(bases[b], lens[l], strides[s], hint);
            hint = 1 - hint;
        end

        // R7: done persists and the engine stays quiet
        force_busy = 0;
        force_ready = 1;
        repeat (3) begin
            step();
            chk(eng_done && !eng_busy && !pf_valid, "R7", "quiet after done",
                int'(pf_valid), 0);
        end

        // R9: start coinciding with acceptance of a held request
        force_busy = 0;
        force_ready = 0;
        start_desc(16'h0100, 640, 64, 1);
        step();
        d_start = 0;
        repeat (3) step();
        chk(pf_valid && int'(pf_line) == 4, "R9", "held old line", int'(pf_line), 4);
        start_desc(16'h2000, 256, 128, 0);
        force_ready = 1;
        step();
        chk(hs && hs_line == 4 && hs_hint == 1'b1, "R9", "same-cycle accept belongs to old",
            hs_line, 4);
        d_start = 0;
        force_busy = -1;
        force_ready = -1;
        compute_exp(16'h2000, 256, 128, 0);
        follow("R9");

        // R9: start over a held request that is never accepted
        force_busy = 0;
        force_ready = 0;
        start_desc(16'h0100, 640, 64, 1);
        step();
        d_start = 0;
        repeat (2) step();
        start_desc(16'h0455, 200, 40, 0);
        step();
        chk(!hs, "R9", "no accept while held", int'(hs), 0);
        d_start = 0;
        force_busy = -1;
        force_ready = -1;
        compute_exp(16'h0455, 200, 40, 0);
        follow("R9");

        finish_run();
    end

endmodule